// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block sits on the host side of a three-wire serial EEPROM link and runs from a fast system clock. A single request carries a command code, a word address and write data. The block turns the request into a serial frame with chip select, a serial clock and a data line. The clock high and low times are counted in system clocks and supplied with each request, so one netlist can serve slow and fast parts.

For read requests the block collects the returned word and presents it when it reports completion. For commands that start an internal programming cycle, the block first drops chip select for the minimum deselect time. It then raises chip select again, waits for the status output of the memory to settle, and polls that status line once per system clock until the memory reports ready or a poll limit runs out. Every command ends with a deselect gap, followed by a one-cycle done pulse; the next request may be presented in that same cycle.

Top module: `ser_eeprom_host`

## Requirements
- R1: After reset, and whenever no command is in progress, `cs_o`, `sclk_o`, `sd_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A frame sends a 1, then a 2-bit opcode, then `ADDR_W` address bits, then (for write-type commands) `DATA_W` data bits, each field MSB first. Command codes are 0 read (opcode 10), 1 write (opcode 01) and 2 erase (opcode 11).
- R3: Codes 3 unlock-writes, 4 lock-writes, 5 erase-all and 6 fill-all use opcode 00. The two top address bits are 11, 00, 10 and 01 respectively, and the lower address bits are 0.
- R4: From the cycle after a request is accepted, `cs_o` is 1. Each bit spends `sclk_low_i` cycles with `sclk_o` low, then `sclk_high_i` cycles with `sclk_o` high. `sd_o` changes only in the cycle in which `sclk_o` falls, so it stays stable while `sclk_o` is high.
- R5: Read, write and fill-all frames have 3+`ADDR_W`+`DATA_W` clocks, and the other commands have 3+`ADDR_W` clocks. During the data clocks of a read, `sd_o` is 0.
- R6: A read samples `sd_i` at the last system clock of the high phase of each of its final `DATA_W` serial clocks, MSB first. `rdata_o` holds the result from the done cycle onward.
- R7: After the last serial clock, `cs_o` stays low for `CS_GAP_CYC` cycles before it rises again or before done is reported.
- R8: After the gap, codes 1, 2, 5 and 6 raise `cs_o` and ignore `sd_i` for `STATUS_CYC` cycles. They then sample `sd_i` once per cycle with `sclk_o` low, and the first 1 ends polling.
- R9: If none of `poll_limit_i` samples is 1, the command still ends through the final gap, and `timeout_o` is 1 in the done cycle. A 1 on the last allowed sample counts as ready.
- R10: After a final gap of `CS_GAP_CYC` low cycles, `done_o` is 1 for exactly one cycle with `busy_o` low, and a request in that cycle is accepted.
- R11: A request while busy has no effect on the running command. Command code 7 is never accepted and leaves all outputs at 0.
- R12: `sclk_high_i`, `sclk_low_i` and `poll_limit_i` are captured when a request is accepted. Changing them while the command runs has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_cmd_i | input | 3 | Command code |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| sclk_high_i | input | CNT_W | Serial clock high time in system clocks |
| sclk_low_i | input | CNT_W | Serial clock low time in system clocks |
| poll_limit_i | input | POLL_W | Maximum number of ready samples |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Ready not seen, valid with done |
| rdata_o | output | DATA_W | Last word read |
| cs_o | output | 1 | Chip select to the memory |
| sclk_o | output | 1 | Serial clock to the memory |
| sd_o | output | 1 | Serial data to the memory |
| sd_i | input | 1 | Serial data and status from the memory |

## Verification
The bench builds the block with a 6-bit address and a 16-bit word, a 3-cycle deselect gap, a 4-cycle status wait, 8-bit timing counters and an 8-bit poll counter. These short settings let every phase of every command fit in tens of cycles. Both the exact timeout boundary and a ready that arrives on the final allowed sample are therefore reached, as are clock shapes from 2/2 to 5/4 cycles. Requests and changed timing inputs are injected in the middle of frames to show that they are ignored.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

  localparam logic [2:0] CMD_READ      = 3'd0;
  localparam logic [2:0] CMD_WRITE     = 3'd1;
  localparam logic [2:0] CMD_ERASE     = 3'd2;
  localparam logic [2:0] CMD_WR_UNLOCK = 3'd3;
  localparam logic [2:0] CMD_WR_LOCK   = 3'd4;
  localparam logic [2:0] CMD_ERASE_ALL = 3'd5;
  localparam logic [2:0] CMD_FILL_ALL  = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_GAP_PRE, ST_WAIT, ST_POLL, ST_GAP_END
  } state_e;

  typedef struct packed {
    logic valid;
    logic is_read;
    logic is_prog;
    logic long_frame;
  } cmd_info_t;

  function automatic cmd_info_t decode_cmd(input logic [2:0] c);
    cmd_info_t r;
    r = '0;
    case (c)
      CMD_READ:      begin r.valid = 1'b1; r.is_read = 1'b1; r.long_frame = 1'b1; end
      CMD_WRITE:     begin r.valid = 1'b1; r.is_prog = 1'b1; r.long_frame = 1'b1; end
      CMD_ERASE:     begin r.valid = 1'b1; r.is_prog = 1'b1; end
      CMD_WR_UNLOCK: r.valid = 1'b1;
      CMD_WR_LOCK:   r.valid = 1'b1;
      CMD_ERASE_ALL: begin r.valid = 1'b1; r.is_prog = 1'b1; end
      CMD_FILL_ALL:  begin r.valid = 1'b1; r.is_prog = 1'b1; r.long_frame = 1'b1; end
      default:       r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] opcode_of(input logic [2:0] c);
    case (c)
      CMD_READ:  return 2'b10;
      CMD_WRITE: return 2'b01;
      CMD_ERASE: return 2'b11;
      default:   return 2'b00;
    endcase
  endfunction

  // upper address bits that select the opcode-00 variants
  function automatic logic [1:0] subcode_of(input logic [2:0] c);
    case (c)
      CMD_WR_UNLOCK: return 2'b11;
      CMD_ERASE_ALL: return 2'b10;
      CMD_FILL_ALL:  return 2'b01;
      default:       return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/ser_eeprom_framer.sv
module ser_eeprom_framer
  import ser_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int FRAME_W = 3 + ADDR_W + DATA_W,
  localparam int SHORT_W = 3 + ADDR_W,
  localparam int BCNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic [2:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [BCNT_W-1:0]  nbits_o,
  output cmd_info_t          info_o
);

  logic [1:0]        op;
  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] data_eff;

  always_comb begin
    info_o   = decode_cmd(cmd_i);
    op       = opcode_of(cmd_i);
    addr_eff = (op == 2'b00) ? {subcode_of(cmd_i), {(ADDR_W-2){1'b0}}} : addr_i;
    data_eff = (info_o.long_frame && !info_o.is_read) ? wdata_i : '0;
    frame_o  = {1'b1, op, addr_eff, data_eff};
    nbits_o  = info_o.long_frame ? BCNT_W'(FRAME_W) : BCNT_W'(SHORT_W);
  end

endmodule

// File: rtl/ser_eeprom_timer.sv
module ser_eeprom_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // an expired phase stays expired until reloaded
  assert_timer_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && !load_i |=> zero_o);

endmodule

// File: rtl/ser_eeprom_shifter.sv
module ser_eeprom_shifter #(
  parameter int FRAME_W = 25,
  parameter int DATA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  input  logic               clear_i,
  input  logic               cap_i,
  input  logic               sd_i,
  output logic               sd_o,
  output logic [DATA_W-1:0]  rx_o
);

  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= frame_i;
    else if (clear_i) sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rx_q <= '0;
    else if (cap_i) rx_q <= {rx_q[DATA_W-2:0], sd_i};
  end

  assign sd_o = sh_q[FRAME_W-1];
  assign rx_o = rx_q;

  assert_shift_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !shift_i && !clear_i && !cap_i);

endmodule

// File: rtl/ser_eeprom_host.sv
module ser_eeprom_host
  import ser_eeprom_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int POLL_W     = 23,
  parameter int CS_GAP_CYC = 50,
  parameter int STATUS_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]  sclk_high_i,
  input  logic [CNT_W-1:0]  sclk_low_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sd_o,
  input  logic              sd_i
);

  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);
  localparam int GAP_W   = $clog2(CS_GAP_CYC + 1);
  localparam int STS_W   = $clog2(STATUS_CYC + 1);
  localparam int TMP_W   = (GAP_W > STS_W) ? GAP_W : STS_W;
  localparam int TMR_W   = (CNT_W > TMP_W) ? CNT_W : TMP_W;
  localparam int RUN_W   = GAP_W + 1;

  function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  // request decode
  logic [FRAME_W-1:0] frame;
  logic [BCNT_W-1:0]  nbits;
  cmd_info_t          info;

  ser_eeprom_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_framer (
    .cmd_i   (req_cmd_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .frame_o (frame),
    .nbits_o (nbits),
    .info_o  (info)
  );

  // state
  state_e             state_q, state_d;
  logic               cs_q, cs_d, sclk_q, sclk_d;
  logic               done_q, done_d, to_q, to_d, flag_q, flag_d;
  logic               rd_q, prog_q;
  logic [CNT_W-1:0]   hi_q, lo_q;
  logic [POLL_W-1:0]  lim_q;
  logic [BCNT_W-1:0]  bits_q, bits_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               latch;

  // datapath strobes
  logic               tmr_load, tmr_zero, poll_load, poll_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic [POLL_W-1:0]  poll_val;
  logic               sh_load, sh_shift, sh_clear, sh_cap;
  logic [DATA_W-1:0]  rx;

  ser_eeprom_timer #(.W(TMR_W)) i_phase_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  ser_eeprom_timer #(.W(POLL_W)) i_poll_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (poll_load),
    .load_val_i (poll_val),
    .zero_o     (poll_zero)
  );

  ser_eeprom_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .frame_i (frame),
    .shift_i (sh_shift),
    .clear_i (sh_clear),
    .cap_i   (sh_cap),
    .sd_i    (sd_i),
    .sd_o    (sd_o),
    .rx_o    (rx)
  );

  assign poll_val = (lim_q == '0) ? '0 : lim_q - 1'b1;

  always_comb begin
    state_d   = state_q;
    cs_d      = cs_q;
    sclk_d    = sclk_q;
    done_d    = 1'b0;
    to_d      = 1'b0;
    flag_d    = flag_q;
    bits_d    = bits_q;
    rdata_d   = rdata_q;
    latch     = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    poll_load = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    sh_clear  = 1'b0;
    sh_cap    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i && info.valid) begin
          latch    = 1'b1;
          sh_load  = 1'b1;
          bits_d   = nbits;
          cs_d     = 1'b1;
          sclk_d   = 1'b0;
          flag_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(len_m1(sclk_low_i));
          state_d  = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(len_m1(hi_q));
          state_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          sclk_d   = 1'b0;
          sh_cap   = rd_q && (bits_q <= BCNT_W'(DATA_W));
          bits_d   = bits_q - 1'b1;
          tmr_load = 1'b1;
          if (bits_q == BCNT_W'(1)) begin
            cs_d     = 1'b0;
            sh_clear = 1'b1;
            tmr_val  = TMR_W'(CS_GAP_CYC - 1);
            state_d  = prog_q ? ST_GAP_PRE : ST_GAP_END;
          end else begin
            sh_shift = 1'b1;
            tmr_val  = TMR_W'(len_m1(lo_q));
            state_d  = ST_LOW;
          end
        end
      end
      ST_GAP_PRE: begin
        if (tmr_zero) begin
          cs_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(STATUS_CYC - 1);
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          poll_load = 1'b1;
          state_d   = ST_POLL;
        end
      end
      ST_POLL: begin
        if (sd_i || poll_zero) begin
          flag_d   = !sd_i;
          cs_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CS_GAP_CYC - 1);
          state_d  = ST_GAP_END;
        end
      end
      ST_GAP_END: begin
        if (tmr_zero) begin
          done_d  = 1'b1;
          to_d    = flag_q;
          if (rd_q) rdata_d = rx;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      flag_q  <= 1'b0;
      bits_q  <= '0;
      rdata_q <= '0;
      rd_q    <= 1'b0;
      prog_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
      to_q    <= to_d;
      flag_q  <= flag_d;
      bits_q  <= bits_d;
      rdata_q <= rdata_d;
      if (latch) begin
        rd_q   <= info.is_read;
        prog_q <= info.is_prog;
        hi_q   <= sclk_high_i;
        lo_q   <= sclk_low_i;
        lim_q  <= poll_limit_i;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign rdata_o   = rdata_q;
  assign cs_o      = cs_q;
  assign sclk_o    = sclk_q;

  // deselect run length, saturating, for the gap check
  logic [RUN_W-1:0] cs_low_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cs_low_run <= RUN_W'(CS_GAP_CYC);
    else if (cs_q)                            cs_low_run <= '0;
    else if (cs_low_run < RUN_W'(CS_GAP_CYC)) cs_low_run <= cs_low_run + 1'b1;
  end

  assert_cs_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> cs_low_run >= RUN_W'(CS_GAP_CYC));

  assert_sd_stable_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sd_o));

  assert_sclk_in_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(cs_o) && cs_o);

  assert_poll_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT || state_q == ST_POLL) |-> cs_o && !sclk_o);

  assert_timeout_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o && !sclk_o && !busy_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cs_o && !sclk_o && !sd_o);

endmodule

// File: tb/test_ser_eeprom_host.sv
`timescale 1ns/1ps
module test_ser_eeprom_host;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int GAP = 3;
  localparam int STS = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [2:0]    req_cmd_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [7:0]    sclk_high_i = 8'd2;
  logic [7:0]    sclk_low_i = 8'd2;
  logic [7:0]    poll_limit_i = 8'd8;
  logic          busy_o, done_o, timeout_o, cs_o, sclk_o, sd_o;
  logic          sd_i = 1'b0;
  logic [DW-1:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit intr = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ser_eeprom_host #(
    .ADDR_W(AW), .DATA_W(DW), .CNT_W(8), .POLL_W(8),
    .CS_GAP_CYC(GAP), .STATUS_CYC(STS)
  ) i_ser_eeprom_host (
    .clk_i, .rst_ni, .req_valid_i, .req_cmd_i, .req_addr_i, .req_wdata_i,
    .sclk_high_i, .sclk_low_i, .poll_limit_i,
    .busy_o, .done_o, .timeout_o, .rdata_o, .cs_o, .sclk_o, .sd_o, .sd_i
  );

  task automatic check_vec(input logic [5:0] exp, input string tag);
    logic [5:0] act;
    act = {cs_o, sclk_o, sd_o, busy_o, done_o, timeout_o};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t {cs,sclk,sd,busy,done,to}=%b expected %b", tag, $time, act, exp);
    end
  endtask

  // one system clock of the reference: advance, then compare
  task automatic step(input logic [5:0] exp, input string tag);
    @(negedge clk_i);
    cyc++;
    if (cyc == 1) req_valid_i = 1'b0;
    if (intr && cyc == 3) begin
      req_valid_i  = 1'b1;
      req_cmd_i    = 3'd2;
      sclk_high_i  = sclk_high_i + 8'd3;
      sclk_low_i   = sclk_low_i + 8'd2;
      poll_limit_i = 8'd1;
    end
    if (intr && cyc == 4) req_valid_i = 1'b0;
    check_vec(exp, tag);
  endtask

  task automatic run_cmd(input int cmd, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                         input int hi, input int lo, input int lim, input int rdy,
                         input logic [DW-1:0] rword, input bit intrude);
    logic bits[$];
    logic [1:0] op;
    logic [AW-1:0] a;
    bit is_rd, is_pg, to;
    int nb;
    is_rd = (cmd == 0);
    is_pg = (cmd == 1 || cmd == 2 || cmd == 5 || cmd == 6);
    a = addr;
    case (cmd)
      0: op = 2'b10;
      1: op = 2'b01;
      2: op = 2'b11;
      3: begin op = 2'b00; a = {2'b11, 4'b0}; end
      4: begin op = 2'b00; a = '0; end
      5: begin op = 2'b00; a = {2'b10, 4'b0}; end
      default: begin op = 2'b00; a = {2'b01, 4'b0}; end
    endcase
    bits.push_back(1'b1);
    bits.push_back(op[1]);
    bits.push_back(op[0]);
    for (int i = AW - 1; i >= 0; i--) bits.push_back(a[i]);
    if (cmd == 0) for (int i = 0; i < DW; i++) bits.push_back(1'b0);
    if (cmd == 1 || cmd == 6) for (int i = DW - 1; i >= 0; i--) bits.push_back(wd[i]);
    nb = bits.size();

    req_cmd_i    = cmd[2:0];
    req_addr_i   = addr;
    req_wdata_i  = wd;
    sclk_high_i  = hi[7:0];
    sclk_low_i   = lo[7:0];
    poll_limit_i = lim[7:0];
    req_valid_i  = 1'b1;
    cyc  = 0;
    intr = intrude;

    for (int i = 0; i < nb; i++)
      for (int ph = 0; ph < 2; ph++)
        for (int k = 0; k < (ph ? hi : lo); k++) begin
          step({1'b1, ph[0], bits[i], 1'b1, 2'b00}, "R2 R3 R4 R5 R12 frame");
          sd_i = (is_rd && i >= nb - DW) ? rword[DW - 1 - (i - (nb - DW))] : 1'b1;
        end
    for (int k = 0; k < GAP; k++) begin
      step(6'b000100, "R7 gap");
      sd_i = 1'b1;
    end
    to = 1'b0;
    if (is_pg) begin
      for (int k = 0; k < STS; k++) begin
        step(6'b100100, "R8 status wait");
        sd_i = 1'b1;
      end
      to = (rdy >= lim);
      for (int p = 0; p < lim; p++) begin
        step(6'b100100, "R8 R9 poll");
        sd_i = (p >= rdy);
        if (p >= rdy) break;
      end
      for (int k = 0; k < GAP; k++) begin
        step(6'b000100, "R7 R10 end gap");
        sd_i = 1'b1;
      end
    end
    step({5'b00001, to}, "R9 R10 done");
    sd_i = 1'b0;
    if (is_rd) begin
      n_cmp++;
      if (rdata_o !== rword) begin
        n_bad++;
        $display("FAIL R6 rdata=%h expected %h", rdata_o, rword);
      end
    end
    intr = 1'b0;
  endtask

  task automatic bad_code;
    req_cmd_i   = 3'd7;
    req_valid_i = 1'b1;
    cyc  = 0;
    intr = 1'b0;
    for (int k = 0; k < 8; k++) step(6'b000000, "R11 code 7");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_vec(6'b000000, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_vec(6'b000000, "R1 after reset");
    run_cmd(3, 6'h00, 16'h0000, 2, 3, 8, 0, 16'h0, 1'b0);
    run_cmd(1, 6'h2A, 16'hBEEF, 2, 3, 20, 5, 16'h0, 1'b0);
    run_cmd(0, 6'h15, 16'h0000, 3, 2, 8, 0, 16'hA5C3, 1'b0);
    run_cmd(0, 6'h3F, 16'h0000, 5, 4, 8, 0, 16'h8001, 1'b1);
    run_cmd(2, 6'h01, 16'h0000, 2, 2, 6, 0, 16'h0, 1'b0);
    run_cmd(5, 6'h00, 16'h0000, 2, 2, 4, 3, 16'h0, 1'b0);
    run_cmd(6, 6'h00, 16'h1234, 2, 2, 4, 4, 16'h0, 1'b0);
    bad_code();
    run_cmd(4, 6'h3F, 16'hFFFF, 4, 2, 8, 0, 16'h0, 1'b0);
    run_cmd(1, 6'h33, 16'h5A0F, 2, 2, 9, 2, 16'h0, 1'b1);
    run_cmd(0, 6'h00, 16'h0000, 2, 2, 8, 0, 16'hFFFF, 1'b0);
    repeat (4) step(6'b000000, "R1 idle");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired, run hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule